// File: doc/BRIEF.md
# Coprocessor Task Interrupt Router

This block sits between a coprocessor that runs numbered tasks and the interrupt controller of a host CPU. For each of eight tasks it produces a one-cycle interrupt pulse toward the host. The pulse comes from one of two sources: the hardware end-of-task strobe that the coprocessor raises when a task finishes, or a forced interrupt that coprocessor software requests by writing a register.

A per-task select register picks the source. With the select bit clear, the end-of-task strobe passes through to the host. With the bit set, the strobe is dropped, so the task can finish without disturbing the host and raise its interrupt later by software. A force write always raises the interrupt, whatever the select bit holds.

The block has two register ports, and each has its own access rights. The coprocessor port can read and write the select register and can write the force register. The host port can only read the select register. Every other access through either port is ignored and reads back zero. Read data is combinational and reflects the register contents at the start of the current cycle.

Top module: `coproc_irq_router`

## Requirements
- R1: After reset the select register is 0 and every interrupt output is 0. Reads through both ports return 0.
- R2: A coprocessor write to word offset 0 loads the select register from data bits [7:0], where bit 0 belongs to task 1 and bit 7 to task 8. Bits [15:8] are reserved. They are not stored and always read as 0. The value can be read back through both ports at offset 0.
- R3: When a task's select bit is 0, an end-of-task strobe on that task produces an interrupt pulse on the matching output in the next cycle.
- R4: When a task's select bit is 1, an end-of-task strobe on that task produces no interrupt.
- R5: A coprocessor write to offset 2 raises a one-cycle pulse, in the next cycle, on every task output whose data bit is 1. All of these pulses occur in the same cycle. Data bits that are 0 have no effect.
- R6: A force raises the interrupt whatever the task's select bit holds. Each output is the OR of its gated end-of-task strobe and its force bit.
- R7: A coprocessor read of offset 2 returns 0.
- R8: Host writes to any offset change nothing. A host access to offset 2 raises no interrupt and reads back 0.
- R9: Coprocessor writes to any offset other than 0 and 2 change nothing, and reads of those offsets return 0.
- R10: When a coprocessor write to offset 0 and a host read fall in the same cycle, the host read returns the old select value. The new value appears from the next cycle.
- R11: An end-of-task strobe that arrives in the same cycle as a select write is gated by the old select value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cp_req_i | input | 1 | Coprocessor access valid |
| cp_we_i | input | 1 | Coprocessor access is a write |
| cp_addr_i | input | 4 | Coprocessor word offset |
| cp_wdata_i | input | 16 | Coprocessor write data |
| cp_rdata_o | output | 16 | Coprocessor read data |
| host_req_i | input | 1 | Host access valid |
| host_we_i | input | 1 | Host access is a write (ignored) |
| host_addr_i | input | 4 | Host word offset |
| host_rdata_o | output | 16 | Host read data |
| eot_i | input | 8 | End-of-task strobes, bit 0 = task 1 |
| irq_o | output | 8 | Interrupt pulses to the host, bit 0 = task 1 |

## Verification
The bench sets a mix of select bits and drives all-ones end-of-task strobes. A design that ignores the select bits, or inverts them, then pulses the wrong set of outputs. Forces are applied to tasks that are selected and to tasks that are not, and in the same cycle as a strobe. This catches a force gated by the select bit, and a design that picks one source instead of ORing both. Host writes, host accesses to the force offset and coprocessor writes to reserved offsets are each followed by a read-back and an interrupt check, so a lax address or master check shows up as a changed select value or a stray pulse. A select write is placed in the same cycle as a host read and as a strobe. A design that forwards the new value shows the new select value a cycle early.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 16;
  localparam logic [ADDR_W-1:0] OFS_SEL = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_FRC = 4'h2;
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_TASKS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cp_req_i,
  input  logic                 cp_we_i,
  input  logic [ADDR_W-1:0]    cp_addr_i,
  input  logic [DATA_W-1:0]    cp_wdata_i,
  output logic [DATA_W-1:0]    cp_rdata_o,
  input  logic                 host_req_i,
  input  logic                 host_we_i,
  input  logic [ADDR_W-1:0]    host_addr_i,
  output logic [DATA_W-1:0]    host_rdata_o,
  output logic [NUM_TASKS-1:0] sel_o,
  output logic [NUM_TASKS-1:0] frc_o
);
  logic [NUM_TASKS-1:0] sel_q;
  logic                 sel_wr, frc_wr;
  logic                 unused_hi;

  assign unused_hi = ^cp_wdata_i;
  assign sel_wr = cp_req_i && cp_we_i && (cp_addr_i == OFS_SEL);
  assign frc_wr = cp_req_i && cp_we_i && (cp_addr_i == OFS_FRC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (sel_wr) sel_q <= cp_wdata_i[NUM_TASKS-1:0];
  end

  assign frc_o = frc_wr ? cp_wdata_i[NUM_TASKS-1:0] : '0;
  assign sel_o = sel_q;

  // force offset reads 0; reserved bits read 0
  assign cp_rdata_o   = (cp_req_i && !cp_we_i && cp_addr_i == OFS_SEL)
                        ? DATA_W'(sel_q) : '0;
  assign host_rdata_o = (host_req_i && !host_we_i && host_addr_i == OFS_SEL)
                        ? DATA_W'(sel_q) : '0;
endmodule

// File: rtl/irq_router_chan.sv
module irq_router_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eot_i,
  input  logic sel_i,
  input  logic frc_i,
  output logic irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (eot_i && !sel_i) || frc_i;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/coproc_irq_router.sv
module coproc_irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_TASKS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cp_req_i,
  input  logic                 cp_we_i,
  input  logic [ADDR_W-1:0]    cp_addr_i,
  input  logic [DATA_W-1:0]    cp_wdata_i,
  output logic [DATA_W-1:0]    cp_rdata_o,
  input  logic                 host_req_i,
  input  logic                 host_we_i,
  input  logic [ADDR_W-1:0]    host_addr_i,
  output logic [DATA_W-1:0]    host_rdata_o,
  input  logic [NUM_TASKS-1:0] eot_i,
  output logic [NUM_TASKS-1:0] irq_o
);
  logic [NUM_TASKS-1:0] sel_w, frc_w;

  irq_router_regs #(.NUM_TASKS(NUM_TASKS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cp_req_i(cp_req_i), .cp_we_i(cp_we_i), .cp_addr_i(cp_addr_i),
    .cp_wdata_i(cp_wdata_i), .cp_rdata_o(cp_rdata_o),
    .host_req_i(host_req_i), .host_we_i(host_we_i), .host_addr_i(host_addr_i),
    .host_rdata_o(host_rdata_o),
    .sel_o(sel_w), .frc_o(frc_w)
  );

  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_chan
    irq_router_chan u_chan (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .eot_i(eot_i[t]), .sel_i(sel_w[t]), .frc_i(frc_w[t]),
      .irq_o(irq_o[t])
    );
  end
endmodule

// File: rtl/coproc_irq_router_chk.sv
module coproc_irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_TASKS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cp_req_i,
  input logic                 cp_we_i,
  input logic [ADDR_W-1:0]    cp_addr_i,
  input logic [DATA_W-1:0]    cp_wdata_i,
  input logic [DATA_W-1:0]    cp_rdata_o,
  input logic                 host_req_i,
  input logic                 host_we_i,
  input logic [DATA_W-1:0]    host_rdata_o,
  input logic [NUM_TASKS-1:0] eot_i,
  input logic [NUM_TASKS-1:0] sel_i,
  input logic [NUM_TASKS-1:0] irq_o
);
  logic                 frc_wr, sel_wr;
  logic [NUM_TASKS-1:0] gated, fbits;
  assign frc_wr = cp_req_i && cp_we_i && (cp_addr_i == OFS_FRC);
  assign sel_wr = cp_req_i && cp_we_i && (cp_addr_i == OFS_SEL);
  assign gated  = eot_i & ~sel_i;
  assign fbits  = cp_wdata_i[NUM_TASKS-1:0];

  assert_eot_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gated) |=> ((irq_o & $past(gated)) == $past(gated)));
  assert_eot_block_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frc_wr |=> ((irq_o & ~$past(gated)) == '0));
  assert_force_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frc_wr |=> ((irq_o & $past(fbits)) == $past(fbits)));
  assert_force_rd_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_req_i && !cp_we_i && cp_addr_i == OFS_FRC) |-> (cp_rdata_o == '0));
  assert_host_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && host_we_i && !sel_wr) |=> $stable(sel_i));
  assert_resv_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((host_rdata_o >> NUM_TASKS) == '0) && ((cp_rdata_o >> NUM_TASKS) == '0));
endmodule

bind coproc_irq_router coproc_irq_router_chk #(.NUM_TASKS(NUM_TASKS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .cp_req_i(cp_req_i), .cp_we_i(cp_we_i), .cp_addr_i(cp_addr_i),
  .cp_wdata_i(cp_wdata_i), .cp_rdata_o(cp_rdata_o),
  .host_req_i(host_req_i), .host_we_i(host_we_i), .host_rdata_o(host_rdata_o),
  .eot_i(eot_i), .sel_i(sel_w), .irq_o(irq_o)
);

// File: tb/sim_coproc_irq_router.sv
module sim_coproc_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cp_req = 0, cp_we = 0;
  logic [3:0]  cp_addr = '0;
  logic [15:0] cp_wdata = '0, cp_rdata;
  logic        host_req = 0, host_we = 0;
  logic [3:0]  host_addr = '0;
  logic [15:0] host_rdata;
  logic [7:0]  eot = '0, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  coproc_irq_router u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cp_req_i(cp_req), .cp_we_i(cp_we), .cp_addr_i(cp_addr),
    .cp_wdata_i(cp_wdata), .cp_rdata_o(cp_rdata),
    .host_req_i(host_req), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_rdata_o(host_rdata),
    .eot_i(eot), .irq_o(irq)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cp_req = 0; cp_we = 0; cp_addr = '0; cp_wdata = '0;
    host_req = 0; host_we = 0; host_addr = '0; eot = '0;
  endtask

  // drive one cycle at negedge, advance to next negedge, then idle
  task automatic cp_wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); cp_req = 1; cp_we = 1; cp_addr = a; cp_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic cp_rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); cp_req = 1; cp_we = 0; cp_addr = a; #1 d = cp_rdata;
    @(negedge clk); idle();
  endtask

  task automatic host_rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); host_req = 1; host_we = 0; host_addr = a; #1 d = host_rdata;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 irq", {8'h0, irq}, 16'h0);
    cp_rd(4'h0, d);   chk("R1 cp sel", d, 16'h0);
    host_rd(4'h0, d); chk("R1 host sel", d, 16'h0);
  endtask

  task automatic t_sel_rw();
    logic [15:0] d;
    cp_wr(4'h0, 16'hFFA5);
    cp_rd(4'h0, d);   chk("R2 cp readback", d, 16'h00A5);
    host_rd(4'h0, d); chk("R2 host readback", d, 16'h00A5);
  endtask

  task automatic t_eot_pass();
    cp_wr(4'h0, 16'h0000);
    @(negedge clk); eot = 8'h81;
    @(negedge clk); idle(); chk("R3 pulse", {8'h0, irq}, 16'h0081);
    @(negedge clk); chk("R3 single cycle", {8'h0, irq}, 16'h0000);
  endtask

  task automatic t_eot_block();
    cp_wr(4'h0, 16'h000F);
    @(negedge clk); eot = 8'hFF;
    @(negedge clk); idle(); chk("R4 gated", {8'h0, irq}, 16'h00F0);
  endtask

  task automatic t_force();
    logic [15:0] d;
    cp_wr(4'h0, 16'h000F);
    cp_wr(4'h2, 16'hFF3C); chk("R5 multi force", {8'h0, irq}, 16'h003C);
    @(negedge clk);        chk("R5 force one cycle", {8'h0, irq}, 16'h0000);
    cp_wr(4'h2, 16'h0000); chk("R5 zero force", {8'h0, irq}, 16'h0000);
    @(negedge clk); eot = 8'h11; cp_req = 1; cp_we = 1; cp_addr = 4'h2; cp_wdata = 16'h0001;
    @(negedge clk); idle(); chk("R6 force plus eot", {8'h0, irq}, 16'h0011);
    cp_rd(4'h2, d); chk("R7 force reads 0", d, 16'h0);
  endtask

  task automatic t_host();
    logic [15:0] d;
    @(negedge clk); host_req = 1; host_we = 1; host_addr = 4'h0;
    @(negedge clk); idle();
    host_rd(4'h0, d); chk("R8 host write ignored", d, 16'h000F);
    @(negedge clk); host_req = 1; host_we = 1; host_addr = 4'h2;
    @(negedge clk); idle(); chk("R8 host force ignored", {8'h0, irq}, 16'h0);
    host_rd(4'h2, d); chk("R8 host force read", d, 16'h0);
  endtask

  task automatic t_reserved();
    logic [15:0] d;
    for (int a = 1; a < 16; a++) begin
      if (a == 2) continue;
      cp_wr(4'(a), 16'hFFFF);
      chk("R9 resv write irq", {8'h0, irq}, 16'h0);
    end
    cp_rd(4'h0, d); chk("R9 sel unchanged", d, 16'h000F);
    cp_rd(4'h5, d); chk("R9 resv read", d, 16'h0);
  endtask

  task automatic t_concurrent();
    logic [15:0] d;
    @(negedge clk);
    cp_req = 1; cp_we = 1; cp_addr = 4'h0; cp_wdata = 16'h00F0;
    host_req = 1; host_we = 0; host_addr = 4'h0; eot = 8'h01;
    #1 d = host_rdata; chk("R10 host old value", d, 16'h000F);
    @(negedge clk);
    cp_req = 0; cp_we = 0; eot = '0;
    #1 chk("R10 host new value", host_rdata, 16'h00F0);
    chk("R11 eot gated by old sel", {8'h0, irq}, 16'h0000);
    idle();
    cp_wr(4'h0, 16'h0000);
    @(negedge clk); cp_req = 1; cp_we = 1; cp_addr = 4'h0; cp_wdata = 16'h00FF; eot = 8'h01;
    @(negedge clk); idle(); chk("R11 eot passes old sel", {8'h0, irq}, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sel_rw();
    t_eot_pass();
    t_eot_block();
    t_force();
    t_host();
    t_reserved();
    t_concurrent();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule